// File: doc/BRIEF.md
# Burst-Filled Single-Line Read Buffer

This block keeps one line of four 32-bit words between a processor memory port and a 16-bit external burst interface. Reads and writes arrive on a simple request port with a one-cycle acceptance. Only word addresses from 8000h upward belong to the external window. A request below that window gets an error response and never reaches the external side.

A read whose line is held and valid is answered from the buffer in the following cycle. A read that misses drops the held line. It then asks for one burst and packs the eight 16-bit beats into the four line words, lower half first. It marks the line valid and answers the read. A write inside the window that hits the held line updates the matching word in place, so that later reads stay coherent. A write that misses leaves the line alone. Either write is acknowledged in the next cycle. A flush input drops the line at any time.

Top module: `burst_line_rdbuf`

## Requirements
- R1: A request accepted with an address below 8000h produces rsp_valid=1 with rsp_err=1 in the next cycle and starts no burst; this holds for reads and for writes.
- R2: A read miss raises burst_req in the cycle after acceptance and holds it until the cycle burst_gnt is seen high. While burst_req is high, burst_addr holds the request address with its two low bits cleared.
- R3: After a grant, exactly eight beat_valid cycles are captured and then the line is complete. Beats that arrive when no fill is in progress are ignored and leave the held words unchanged.
- R4: Beat 2k of a burst becomes bits [15:0] of line word k and beat 2k+1 becomes bits [31:16].
- R5: A miss is answered with rsp_valid=1, rsp_err=0 and the requested word two cycles after the edge that captures the eighth beat.
- R6: A read whose address bits [15:2] match a valid held line is answered in the next cycle with the buffered word, with no burst.
- R7: req_ready is 1 when idle. It is 0 from the cycle after a miss is accepted until the cycle its response appears.
- R8: An accepted write inside the window is acknowledged in the next cycle with rsp_err=0. On a hit it replaces the addressed word, and later reads return the new value without a burst. On a miss it changes nothing and starts no burst.
- R9: flush high in a cycle makes the line invalid, and a request in that same cycle sees no hit. A flush during a fill still lets that read be answered, but the filled line is left invalid.
- R10: After reset req_ready=1, burst_req=0, rsp_valid=0 and the line is invalid, so the first read in the window bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drop the held line |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Address outside the external window |
| rsp_rdata | output | 32 | Read data |
| burst_req | output | 1 | Burst request, held until granted |
| burst_gnt | input | 1 | Burst accepted by the external side |
| burst_addr | output | 16 | Word address of the line start |
| beat_valid | input | 1 | A beat is on beat_data |
| beat_data | input | 16 | Burst beat |

## Verification
The hardest case to reach from the ports is a flush that lands while a fill is partway through. The read must still be answered with correct data, yet the line must not become valid. The stimulus issues a miss and lets the bench's burst responder start delivering beats with an idle gap. It then pulses flush a few cycles later, before the last beat. A second read to the same line must then burst again. Stray beats driven while idle, write hits followed by reads, and a mixed random stream are compared every cycle against a behavioural model.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ASK    = 2'd1,
      ST_FILL   = 2'd2,
      ST_ANSWER = 2'd3
   } rd_state_e;
endpackage

// File: rtl/rdbuf_tag_cmp.sv
module rdbuf_tag_cmp #(
   parameter int unsigned TAG_W = 14
) (
   input  logic             line_valid,
   input  logic [TAG_W-1:0] line_tag,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             flush,
   output logic             hit
);
   // a flush in the same cycle hides the line from the request
   assign hit = line_valid && !flush && (line_tag == req_tag);
endmodule

// File: rtl/rdbuf_line_store.sv
module rdbuf_line_store #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned BEAT_W     = 16,
   parameter int unsigned LINE_WORDS = 4,
   localparam int unsigned BPW   = WORD_W / BEAT_W,
   localparam int unsigned BEATS = LINE_WORDS * BPW,
   localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int unsigned OFS_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
   input  logic              clk,
   input  logic              beat_we,
   input  logic [CNT_W-1:0]  beat_idx,
   input  logic [BEAT_W-1:0] beat_data,
   input  logic              word_we,
   input  logic [OFS_W-1:0]  word_sel,
   input  logic [WORD_W-1:0] word_data,
   input  logic [OFS_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_word
);
   logic [LINE_WORDS*WORD_W-1:0] line_flat;

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      for (genvar h = 0; h < BPW; h++) begin : g_half
         localparam int unsigned SLOT = w * BPW + h;
         logic [BEAT_W-1:0] half_q;
         always_ff @(posedge clk) begin
            if (beat_we && (beat_idx == CNT_W'(SLOT))) begin
               half_q <= beat_data;
            end else if (word_we && (word_sel == OFS_W'(w))) begin
               half_q <= word_data[h*BEAT_W +: BEAT_W];
            end
         end
         assign line_flat[w*WORD_W + h*BEAT_W +: BEAT_W] = half_q;
      end
   end

   assign rd_word = line_flat[rd_sel*WORD_W +: WORD_W];
endmodule

// File: rtl/rdbuf_fill_fsm.sv
module rdbuf_fill_fsm
   import rdbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BEATS  = 8,
   localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_miss,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic              flush,
   input  logic              burst_gnt,
   input  logic              beat_valid,
   output logic              burst_req,
   output logic [ADDR_W-1:0] burst_addr,
   output logic              beat_we,
   output logic [CNT_W-1:0]  beat_idx,
   output logic              fill_done,
   output logic              keep_line,
   output logic              answer,
   output logic              idle
);
   rd_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              kill_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         kill_q  <= 1'b0;
         addr_q  <= '0;
      end else begin
         // a flush seen after the miss started spoils the line being filled
         if (state_q == ST_IDLE)  kill_q <= 1'b0;
         else if (flush)          kill_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: if (start_miss) begin
               state_q <= ST_ASK;
               addr_q  <= miss_addr;
            end
            ST_ASK: if (burst_gnt) begin
               state_q <= ST_FILL;
               cnt_q   <= '0;
            end
            ST_FILL: if (beat_valid) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(BEATS - 1)) state_q <= ST_ANSWER;
            end
            ST_ANSWER: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign burst_req  = (state_q == ST_ASK);
   assign burst_addr = addr_q;
   assign beat_we    = (state_q == ST_FILL) && beat_valid;
   assign beat_idx   = cnt_q;
   assign fill_done  = beat_we && (cnt_q == CNT_W'(BEATS - 1));
   assign keep_line  = !kill_q && !flush;
   assign answer     = (state_q == ST_ANSWER);
   assign idle       = (state_q == ST_IDLE);
endmodule

// File: rtl/burst_line_rdbuf.sv
module burst_line_rdbuf #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned BEAT_W     = 16,
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned WIN_LO     = 32'h8000,
   parameter bit          WR_UPDATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              burst_req,
   input  logic              burst_gnt,
   output logic [ADDR_W-1:0] burst_addr,
   input  logic              beat_valid,
   input  logic [BEAT_W-1:0] beat_data
);
   localparam int unsigned BPW   = WORD_W / BEAT_W;
   localparam int unsigned BEATS = LINE_WORDS * BPW;
   localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int unsigned OFS_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
   localparam int unsigned TAG_W = ADDR_W - OFS_W;

   // elaboration checks on the parameter set
   if (WORD_W % BEAT_W != 0) begin : g_bad_ratio
      $error("WORD_W must be a multiple of BEAT_W");
   end
   if ((LINE_WORDS < 2) || ((LINE_WORDS & (LINE_WORDS - 1)) != 0)) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if ((ADDR_W < 32) && (WIN_LO >= (32'd1 << ADDR_W))) begin : g_bad_win
      $error("WIN_LO lies outside the address space");
   end

   logic              acc, in_win, hit;
   logic              start_miss, wr_hit, word_we, wr_drop;
   logic              line_valid_q;
   logic [TAG_W-1:0]  line_tag_q;
   logic [OFS_W-1:0]  miss_sel_q, rd_sel;
   logic [WORD_W-1:0] rd_word;
   logic              beat_we, fill_done, keep_line, answer, idle;
   logic [CNT_W-1:0]  beat_idx;
   logic [ADDR_W-1:0] miss_addr;
   logic [TAG_W-1:0]  req_tag;

   assign req_tag   = req_addr[ADDR_W-1:OFS_W];
   assign miss_addr = {req_tag, {OFS_W{1'b0}}};
   assign req_ready = idle;
   assign acc       = req_valid && idle;

   if (WIN_LO == 0) begin : g_win_all
      assign in_win = 1'b1;
   end else begin : g_win_upper
      assign in_win = (req_addr >= ADDR_W'(WIN_LO));
   end

   rdbuf_tag_cmp #(.TAG_W(TAG_W)) u_tag (
      .line_valid (line_valid_q),
      .line_tag   (line_tag_q),
      .req_tag    (req_tag),
      .flush      (flush),
      .hit        (hit)
   );

   assign start_miss = acc && in_win && !req_write && !hit;
   assign wr_hit     = acc && in_win && req_write && hit;

   // write policy: refresh the word in place, or drop the line
   if (WR_UPDATE) begin : g_wr_update
      assign word_we = wr_hit;
      assign wr_drop = 1'b0;
   end else begin : g_wr_drop
      assign word_we = 1'b0;
      assign wr_drop = wr_hit;
   end

   rdbuf_fill_fsm #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_miss (start_miss),
      .miss_addr  (miss_addr),
      .flush      (flush),
      .burst_gnt  (burst_gnt),
      .beat_valid (beat_valid),
      .burst_req  (burst_req),
      .burst_addr (burst_addr),
      .beat_we    (beat_we),
      .beat_idx   (beat_idx),
      .fill_done  (fill_done),
      .keep_line  (keep_line),
      .answer     (answer),
      .idle       (idle)
   );

   assign rd_sel = answer ? miss_sel_q : req_addr[OFS_W-1:0];

   rdbuf_line_store #(
      .WORD_W     (WORD_W),
      .BEAT_W     (BEAT_W),
      .LINE_WORDS (LINE_WORDS)
   ) u_store (
      .clk       (clk),
      .beat_we   (beat_we),
      .beat_idx  (beat_idx),
      .beat_data (beat_data),
      .word_we   (word_we),
      .word_sel  (req_addr[OFS_W-1:0]),
      .word_data (req_wdata),
      .rd_sel    (rd_sel),
      .rd_word   (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_valid_q <= 1'b0;
         line_tag_q   <= '0;
         miss_sel_q   <= '0;
      end else begin
         if (start_miss) begin
            line_tag_q <= req_tag;
            miss_sel_q <= req_addr[OFS_W-1:0];
         end
         if (flush || start_miss || wr_drop) line_valid_q <= 1'b0;
         else if (fill_done && keep_line)    line_valid_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= answer || (acc && (!in_win || req_write || hit));
         rsp_err   <= acc && !in_win;
         if (answer || (acc && in_win && !req_write && hit)) rsp_rdata <= rd_word;
      end
   end
endmodule

// File: rtl/rdbuf_checker.sv
module rdbuf_checker #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFS_W  = 2,
   parameter int unsigned BEATS  = 8,
   parameter int unsigned WIN_LO = 32'h8000
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    flush,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic                    req_write,
   input logic [ADDR_W-1:0]       req_addr,
   input logic                    rsp_valid,
   input logic                    rsp_err,
   input logic                    burst_req,
   input logic                    burst_gnt,
   input logic [ADDR_W-1:0]       burst_addr,
   input logic                    beat_valid,
   input logic                    line_valid,
   input logic [ADDR_W-OFS_W-1:0] line_tag
);
   logic        filling_q;
   logic [15:0] beats_q;

   // counts beats seen between a grant and the following response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filling_q <= 1'b0;
         beats_q   <= '0;
      end else if (burst_req && burst_gnt) begin
         filling_q <= 1'b1;
         beats_q   <= '0;
      end else if (rsp_valid) begin
         filling_q <= 1'b0;
      end else if (filling_q && beat_valid) begin
         beats_q <= beats_q + 16'd1;
      end
   end

   AST_LOW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_addr < ADDR_W'(WIN_LO))) |=> (rsp_valid && rsp_err && !burst_req)); // R1

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_req && !burst_gnt) |=> (burst_req && $stable(burst_addr))); // R2

   AST_BURST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_req) |-> $past(req_valid && req_ready && !req_write && (req_addr >= ADDR_W'(WIN_LO)))); // R2

   AST_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid) |-> (beats_q == 16'(BEATS))); // R3

   AST_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write && !flush && line_valid &&
       (req_addr >= ADDR_W'(WIN_LO)) && (req_addr[ADDR_W-1:OFS_W] == line_tag))
      |=> (rsp_valid && !rsp_err && !burst_req)); // R6

   AST_NO_ACCEPT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> !req_ready); // R7

   AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !line_valid); // R9
endmodule

bind burst_line_rdbuf rdbuf_checker #(
   .ADDR_W (ADDR_W),
   .OFS_W  (OFS_W),
   .BEATS  (BEATS),
   .WIN_LO (WIN_LO)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .burst_req  (burst_req),
   .burst_gnt  (burst_gnt),
   .burst_addr (burst_addr),
   .beat_valid (beat_valid),
   .line_valid (line_valid_q),
   .line_tag   (line_tag_q)
);

// File: tb/tb_burst_line_rdbuf.sv
module tb_burst_line_rdbuf;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        burst_req;
   logic        burst_gnt;
   logic [15:0] burst_addr;
   logic        beat_valid;
   logic [15:0] beat_data;

   logic        drv_gnt = 1'b0, drv_bv = 1'b0, stray_bv = 1'b0;
   logic [15:0] drv_bd = '0, stray_bd = '0;
   assign burst_gnt  = drv_gnt;
   assign beat_valid = drv_bv | stray_bv;
   assign beat_data  = stray_bv ? stray_bd : drv_bd;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_line_rdbuf dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .burst_req(burst_req), .burst_gnt(burst_gnt), .burst_addr(burst_addr),
      .beat_valid(beat_valid), .beat_data(beat_data)
   );

   int n_cmp = 0, n_bad = 0, n_bursts = 0;
   bit done = 0;

   function automatic logic [15:0] mem16(input int i);
      return 16'((i * 40503 + 17) ^ (i >>> 3));
   endfunction

   function automatic logic [31:0] memw(input logic [15:0] a);
      return {mem16(int'(a) * 2 + 1), mem16(int'(a) * 2)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          ms = 0, mcnt = 0;
   bit          mv = 0, mkill = 0;
   logic [13:0] mtag = '0;
   logic [15:0] maddr = '0;
   logic [31:0] mline [4];
   bit          e_ready = 1, e_breq = 0, e_rv = 0, e_re = 0, e_isrd = 0;
   logic [31:0] e_rd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mv = 0; mkill = 0; mcnt = 0;
         e_rv = 0; e_re = 0; e_isrd = 0;
      end else begin
         bit hit, n_rv, n_re, n_rd, clr, setv;
         int old;
         old = ms;
         hit = mv && !flush && (req_addr[15:2] == mtag);
         n_rv = 0; n_re = 0; n_rd = 0; clr = 0; setv = 0;
         case (ms)
            0: if (req_valid) begin
               if (req_addr < 16'h8000) begin n_rv = 1; n_re = 1; end
               else if (req_write) begin
                  n_rv = 1;
                  if (hit) mline[req_addr[1:0]] = req_wdata;
               end else if (hit) begin
                  n_rv = 1; n_rd = 1; e_rd = mline[req_addr[1:0]];
               end else begin
                  ms = 1; maddr = req_addr; mtag = req_addr[15:2]; clr = 1; mkill = 0;
               end
            end
            1: if (burst_gnt) begin ms = 2; mcnt = 0; end
            2: if (beat_valid) begin
               mline[mcnt / 2][(mcnt % 2) * 16 +: 16] = beat_data;
               mcnt++;
               if (mcnt == 8) begin
                  if (!mkill && !flush) setv = 1;
                  ms = 3;
               end
            end
            default: begin n_rv = 1; n_rd = 1; e_rd = mline[maddr[1:0]]; ms = 0; end
         endcase
         if (flush && old != 0) mkill = 1;
         if (clr) mv = 0;
         if (setv) mv = 1;
         if (flush) mv = 0;
         e_rv = n_rv; e_re = n_re; e_isrd = n_rd;
      end
      e_ready = (ms == 0);
      e_breq  = (ms == 1);
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(req_ready == e_ready, "R7 req_ready", 32'(req_ready), 32'(e_ready));
         chk(burst_req == e_breq, "R2 burst_req", 32'(burst_req), 32'(e_breq));
         if (e_breq)
            chk(burst_addr == {maddr[15:2], 2'b00}, "R2 burst_addr", 32'(burst_addr), 32'({maddr[15:2], 2'b00}));
         chk(rsp_valid == e_rv, e_re ? "R1 rsp_valid" : (e_isrd ? "R5 rsp_valid" : "R8 rsp_valid"),
             32'(rsp_valid), 32'(e_rv));
         if (e_rv) chk(rsp_err == e_re, "R1 rsp_err", 32'(rsp_err), 32'(e_re));
         if (e_rv && e_isrd) chk(rsp_rdata == e_rd, "R4 rsp_rdata", rsp_rdata, e_rd);
      end
   end

   // ---------------- external burst responder ----------------
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && burst_req) begin
            logic [15:0] base;
            n_bursts++;
            base = burst_addr;
            repeat (n_bursts % 3) @(negedge clk);
            drv_gnt = 1'b1;
            @(negedge clk);
            drv_gnt = 1'b0;
            for (int b = 0; b < 8; b++) begin
               if (b == 3) @(negedge clk);
               drv_bv = 1'b1;
               drv_bd = mem16(int'(base) * 2 + b);
               @(negedge clk);
               drv_bv = 1'b0;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   logic [31:0] got_d;
   bit          got_e;

   task automatic op(input bit w, input logic [15:0] a, input logic [31:0] d);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      got_d = rsp_rdata; got_e = rsp_err;
      @(negedge clk);
   endtask

   task automatic flush_pulse();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      finish_run();
   end

   initial begin
      int nb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: state after reset
      chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'd1);
      chk(burst_req == 1'b0, "R10 burst_req", 32'(burst_req), 32'd0);
      chk(rsp_valid == 1'b0, "R10 rsp_valid", 32'(rsp_valid), 32'd0);

      // R1: below the window, read and write
      op(0, 16'h1234, '0);
      chk(got_e == 1'b1, "R1 read err", 32'(got_e), 32'd1);
      op(1, 16'h0010, 32'h55);
      chk(got_e == 1'b1, "R1 write err", 32'(got_e), 32'd1);
      chk(n_bursts == 0, "R1 no burst", 32'(n_bursts), 32'd0);

      // R10/R4/R5: first read misses and packs beats in order
      op(0, 16'h8005, '0);
      chk(n_bursts == 1, "R10 first read bursts", 32'(n_bursts), 32'd1);
      chk(got_d == memw(16'h8005), "R4 packed word", got_d, memw(16'h8005));

      // R6: hits on the same line
      op(0, 16'h8006, '0);
      chk(got_d == memw(16'h8006), "R6 hit word", got_d, memw(16'h8006));
      op(0, 16'h8004, '0);
      op(0, 16'h8007, '0);
      chk(got_d == memw(16'h8007), "R6 hit word 3", got_d, memw(16'h8007));
      chk(n_bursts == 1, "R6 no burst on hit", 32'(n_bursts), 32'd1);

      // R3: stray beats while idle change nothing
      for (int i = 0; i < 4; i++) begin
         stray_bv = 1'b1; stray_bd = 16'(16'hA5A0 + i);
         @(negedge clk);
      end
      stray_bv = 1'b0;
      op(0, 16'h8004, '0);
      chk(got_d == memw(16'h8004), "R3 stray beats ignored", got_d, memw(16'h8004));

      // R8: write hit updates, write miss leaves line
      op(1, 16'h8006, 32'hDEADBEEF);
      chk(got_e == 1'b0, "R8 write ack", 32'(got_e), 32'd0);
      op(0, 16'h8006, '0);
      chk(got_d == 32'hDEADBEEF, "R8 updated word", got_d, 32'hDEADBEEF);
      op(1, 16'h9000, 32'h12345678);
      op(0, 16'h8006, '0);
      chk(got_d == 32'hDEADBEEF, "R8 write miss no effect", got_d, 32'hDEADBEEF);
      chk(n_bursts == 1, "R8 no burst for writes", 32'(n_bursts), 32'd1);

      // R9: flush forces a refill
      flush_pulse();
      op(0, 16'h8006, '0);
      chk(n_bursts == 2, "R9 refill after flush", 32'(n_bursts), 32'd2);
      chk(got_d == memw(16'h8006), "R9 refetched word", got_d, memw(16'h8006));

      // R9: flush in the middle of a fill
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hA001;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      flush_pulse();
      while (!rsp_valid) @(negedge clk);
      chk(rsp_rdata == memw(16'hA001), "R9 answer after mid-fill flush", rsp_rdata, memw(16'hA001));
      @(negedge clk);
      nb = n_bursts;
      op(0, 16'hA002, '0);
      chk(n_bursts == nb + 1, "R9 line left invalid", 32'(n_bursts), 32'(nb + 1));

      // mixed stream checked by the model every cycle
      for (int i = 0; i < 300; i++) begin
         logic [15:0] a;
         int k;
         k = $urandom_range(0, 9);
         case (k % 4)
            0: a = 16'h8000;
            1: a = 16'h8004;
            2: a = 16'hC010;
            default: a = 16'h0020;
         endcase
         a = a | 16'($urandom_range(0, 3));
         if (k == 9) flush_pulse();
         else op(k < 3, a, $urandom);
      end

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule